// File: doc/BRIEF.md
# GMII multi-speed byte rate adapter

This block sits between a byte-wide MAC client and a GMII-style port whose clock always runs at the gigabit byte rate, while the link may carry 10, 100 or 1000 Mbps traffic. It scales the byte rate by a repetition factor of 100, 10 or 1. A 2-bit speed input chooses the factor, and the factor applies to every byte of a frame.

On the transmit side the adapter takes one client byte each time it offers a ready pulse. It then holds that byte, along with its enable and error flags, on the GMII lines for the number of clocks in one repetition group. On the receive side the incoming GMII stream carries each byte repeated. The adapter emits one byte per repetition group with a one-clock valid strobe, and it realigns to the start of every frame. The adapter inserts no interframe gap; keeping the gap legal at the current speed is the client's job.

Top module: `gmii_rate_adapter`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `gmii_txd` is 0, `gmii_tx_en` and `gmii_tx_er` are low, `rx_valid`, `rx_dv` and `rx_er` are low, `rx_data` is 0, and `tx_ready` is high.
- R2: The speed code 2'b10 selects a factor of 1. Under it, `tx_ready` is high every clock, and a byte accepted in one clock appears on `gmii_txd` in the next clock for exactly one clock.
- R3: The speed code 2'b01 selects a factor of 10. Under it, `tx_ready` is high for one clock in every 10, and each accepted byte is held on `gmii_txd` for 10 consecutive clocks, starting one clock after it is accepted.
- R4: The speed code 2'b00 selects a factor of 100. Under it, `tx_ready` is high for one clock in every 100, and each accepted byte is held for 100 consecutive clocks.
- R5: The `tx_en` and `tx_er` values sampled with each byte are held on `gmii_tx_en` and `gmii_tx_er` for the same clocks as that byte.
- R6: The speed code 2'b11 behaves exactly like 2'b10 (factor 1) on both transmit and receive.
- R7: On receive, `rx_valid` pulses for one clock, one clock after the first clock of each repetition group. `rx_data` and `rx_er` then carry the GMII byte and error flag from that first clock. `rx_valid` stays low for the rest of the group and while `gmii_rx_dv` is low. `rx_dv` follows `gmii_rx_dv` one clock later.
- R8: A rising edge of `gmii_rx_dv` starts a new repetition group, even after a frame that ended partway through a group.
- R9: A new `speed` value takes effect on transmit only when a byte with `tx_en` low is accepted, and on receive only while `gmii_rx_dv` is low. A frame in progress keeps its factor.
- R10: Back-to-back bytes are accepted with no gap. `tx_ready` returns high in the last clock of each group, so the next byte follows the previous one with no idle clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Gigabit byte clock |
| rst | input | 1 | Synchronous reset, active high |
| speed | input | 2 | Speed code: 00 = 10 Mbps, 01 = 100 Mbps, 10 or 11 = 1 Gbps |
| tx_data | input | 8 | Client transmit byte |
| tx_en | input | 1 | Client transmit enable for the byte |
| tx_er | input | 1 | Client transmit error for the byte |
| tx_ready | output | 1 | High when the client byte is taken at this clock |
| gmii_txd | output | 8 | GMII transmit data, replicated |
| gmii_tx_en | output | 1 | GMII transmit enable, replicated |
| gmii_tx_er | output | 1 | GMII transmit error, replicated |
| gmii_rxd | input | 8 | GMII receive data, repeated per group |
| gmii_rx_dv | input | 1 | GMII receive data valid |
| gmii_rx_er | input | 1 | GMII receive error |
| rx_data | output | 8 | Decimated receive byte |
| rx_dv | output | 1 | Receive data valid, delayed one clock |
| rx_er | output | 1 | Error flag captured with the byte |
| rx_valid | output | 1 | One-clock strobe per received group |

## Verification
A byte accepted on a `tx_ready` clock is due on the GMII transmit lines one clock later. The bench samples the lines on each of the following factor falling edges, and on the last of them it expects `tx_ready` to be high again. A receive group that starts at one clock has its `rx_valid` strobe and captured byte due in the next clock. The bench therefore checks each clock's expectation at the falling edge after it drives that clock's input. Speed changes are made both at idle and in the middle of frames, and the bench checks that the group lengths count the factor that was in force when the frame started.

// File: rtl/gmii_rate_adapter.sv
module gmii_rate_adapter #(
  parameter int DW = 8,
  parameter int SLOW_REP = 100,
  parameter int MID_REP = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    speed,
  input  logic [DW-1:0] tx_data,
  input  logic          tx_en,
  input  logic          tx_er,
  output logic          tx_ready,
  output logic [DW-1:0] gmii_txd,
  output logic          gmii_tx_en,
  output logic          gmii_tx_er,
  input  logic [DW-1:0] gmii_rxd,
  input  logic          gmii_rx_dv,
  input  logic          gmii_rx_er,
  output logic [DW-1:0] rx_data,
  output logic          rx_dv,
  output logic          rx_er,
  output logic          rx_valid
);
  localparam int CW = $clog2(SLOW_REP);

  function automatic logic [CW-1:0] last_of(input logic [1:0] s);
    case (s)
      2'b00:   return CW'(SLOW_REP - 1);
      2'b01:   return CW'(MID_REP - 1);
      default: return '0;
    endcase
  endfunction

  logic [CW-1:0] tx_cnt, rx_cnt;
  logic [1:0]    tx_spd, rx_spd;

  assign tx_ready = (tx_cnt == '0);
  wire [1:0]    tx_grp  = (tx_ready && !tx_en) ? speed : tx_spd;
  wire [CW-1:0] tx_last = last_of(tx_grp);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_cnt     <= '0;
      tx_spd     <= speed;
      gmii_txd   <= '0;
      gmii_tx_en <= 1'b0;
      gmii_tx_er <= 1'b0;
    end else begin
      tx_spd <= tx_grp;
      tx_cnt <= (tx_cnt == tx_last) ? '0 : tx_cnt + 1'b1;
      if (tx_ready) begin
        gmii_txd   <= tx_data;
        gmii_tx_en <= tx_en;
        gmii_tx_er <= tx_er;
      end
    end
  end

  wire [CW-1:0] rx_last  = last_of(rx_spd);
  wire          rx_first = gmii_rx_dv && (rx_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_cnt   <= '0;
      rx_spd   <= speed;
      rx_data  <= '0;
      rx_dv    <= 1'b0;
      rx_er    <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      if (!gmii_rx_dv) rx_spd <= speed;
      if (!gmii_rx_dv)            rx_cnt <= '0;
      else if (rx_cnt == rx_last) rx_cnt <= '0;
      else                        rx_cnt <= rx_cnt + 1'b1;
      rx_dv    <= gmii_rx_dv;
      rx_valid <= rx_first;
      if (rx_first) begin
        rx_data <= gmii_rxd;
        rx_er   <= gmii_rx_er;
      end
    end
  end

  // R3 R4 R5: lines change only after an accepting clock
  p_hold_between_accepts_r5: assert property (@(posedge clk) disable iff (rst)
    !tx_ready |=> $stable({gmii_txd, gmii_tx_en, gmii_tx_er}));

  // R2: an accepted byte appears on the next clock
  p_accept_to_line_r2: assert property (@(posedge clk) disable iff (rst)
    tx_ready |=> (gmii_txd == $past(tx_data)) && (gmii_tx_en == $past(tx_en)));

  // R8: a rising data-valid always yields a strobe
  p_start_strobe_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(gmii_rx_dv) |=> rx_valid);

  // R7: the strobe only occurs inside a frame
  p_strobe_in_frame_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid |-> rx_dv);

  // R7: the strobe lasts one clock unless the factor is 1
  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    rx_valid && (rx_last != '0) && $stable(rx_spd) |=> !rx_valid || $rose(gmii_rx_dv) || !$past(gmii_rx_dv));
endmodule

// File: tb/sim_gmii_rate_adapter.sv
module sim_gmii_rate_adapter;
  logic clk = 0, rst = 1;
  logic [1:0] speed = 2'b10;
  logic [7:0] tx_data = 0, gmii_rxd = 0;
  logic tx_en = 0, tx_er = 0, gmii_rx_dv = 0, gmii_rx_er = 0;
  logic tx_ready, gmii_tx_en, gmii_tx_er, rx_dv, rx_er, rx_valid;
  logic [7:0] gmii_txd, rx_data;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  gmii_rate_adapter u0 (.clk(clk), .rst(rst), .speed(speed),
    .tx_data(tx_data), .tx_en(tx_en), .tx_er(tx_er), .tx_ready(tx_ready),
    .gmii_txd(gmii_txd), .gmii_tx_en(gmii_tx_en), .gmii_tx_er(gmii_tx_er),
    .gmii_rxd(gmii_rxd), .gmii_rx_dv(gmii_rx_dv), .gmii_rx_er(gmii_rx_er),
    .rx_data(rx_data), .rx_dv(rx_dv), .rx_er(rx_er), .rx_valid(rx_valid));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int fac(input logic [1:0] s);
    return (s == 2'b00) ? 100 : (s == 2'b01) ? 10 : 1;
  endfunction

  task automatic wait_ready();
    int guard = 0;
    while (!tx_ready && guard < 300) begin @(negedge clk); guard++; end
    chk(tx_ready, "R10 ready", tx_ready, 1);
  endtask

  task automatic tx_frame(input logic [1:0] s, input int n, input bit mid_change, input string tag);
    int f = fac(s);
    tx_en = 0; tx_er = 0;
    speed = s;
    wait_ready();
    for (int j = 1; j <= f; j++) begin
      @(negedge clk);
      chk(gmii_tx_en == 0, {tag, " idle"}, gmii_tx_en, 0);
    end
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'(i * 37 + s * 11 + 5);
      bit e = (i == 2);
      chk(tx_ready, {tag, " R10 ready"}, tx_ready, 1);
      tx_data = b; tx_en = 1; tx_er = e;
      for (int j = 1; j <= f; j++) begin
        @(negedge clk);
        if (mid_change && i == 0 && j == 1) speed = (s == 2'b01) ? 2'b00 : 2'b01;
        chk(gmii_txd == b, {tag, " data"}, gmii_txd, b);
        chk(gmii_tx_en == 1 && gmii_tx_er == e, "R5 en/er", {gmii_tx_en, gmii_tx_er}, {1'b1, e});
        chk(tx_ready == (j == f), {tag, " ready spacing"}, tx_ready, (j == f));
      end
    end
    tx_en = 0; tx_er = 0; tx_data = 0;
    speed = s;
  endtask

  task automatic rx_frame(input logic [1:0] s, input int n, input int trunc, input bit mid_change, input string tag);
    int f = fac(s);
    bit pv = 0; logic [7:0] pb = 0; bit pe = 0;
    speed = s;
    gmii_rx_dv = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i <= n; i++) begin
      int reps = (i == n) ? trunc : f;
      logic [7:0] b = 8'(i * 53 + s * 7 + 3);
      bit e = (i == 1);
      for (int j = 0; j < reps; j++) begin
        @(negedge clk);
        chk(rx_valid == pv, {tag, " strobe"}, rx_valid, pv);
        if (pv) begin
          chk(rx_data == pb, {tag, " data"}, rx_data, pb);
          chk(rx_er == pe, "R7 err", rx_er, pe);
        end
        if (i == 1 && j == 0 && mid_change) speed = (s == 2'b00) ? 2'b01 : 2'b00;
        gmii_rxd = b; gmii_rx_dv = 1; gmii_rx_er = e;
        pv = (j == 0); pb = b; pe = e;
      end
    end
    @(negedge clk);
    chk(rx_valid == pv, {tag, " last strobe"}, rx_valid, pv);
    gmii_rx_dv = 0; gmii_rx_er = 0;
    @(negedge clk);
    chk(rx_valid == 0, "R7 idle strobe", rx_valid, 0);
    chk(rx_dv == 0, "R7 dv delay", rx_dv, 0);
    speed = s;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(gmii_txd == 0 && gmii_tx_en == 0 && gmii_tx_er == 0, "R1 tx reset", gmii_txd, 0);
    chk(rx_valid == 0 && rx_dv == 0 && rx_er == 0 && rx_data == 0, "R1 rx reset", rx_valid, 0);
    chk(tx_ready == 1, "R1 ready in reset", tx_ready, 1);
    rst = 0;
    @(negedge clk);
    chk(gmii_tx_en == 0 && rx_valid == 0, "R1 after reset", gmii_tx_en, 0);
    tx_frame(2'b10, 6, 0, "R2");
    tx_frame(2'b01, 5, 0, "R3");
    tx_frame(2'b00, 4, 0, "R4");
    tx_frame(2'b11, 6, 0, "R6 tx");
    tx_frame(2'b01, 4, 1, "R9 tx");
    tx_frame(2'b00, 3, 1, "R9 tx slow");
    rx_frame(2'b10, 6, 0, 0, "R7 fast");
    rx_frame(2'b01, 5, 0, 0, "R7 mid");
    rx_frame(2'b00, 3, 0, 0, "R7 slow");
    rx_frame(2'b11, 5, 0, 0, "R6 rx");
    rx_frame(2'b01, 3, 4, 0, "R8 trunc");
    rx_frame(2'b01, 3, 0, 0, "R8 realign");
    rx_frame(2'b00, 2, 37, 0, "R8 trunc slow");
    rx_frame(2'b00, 2, 0, 0, "R8 realign slow");
    rx_frame(2'b01, 4, 0, 1, "R9 rx");
    rx_frame(2'b00, 3, 0, 1, "R9 rx slow");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule